// File: doc/BRIEF.md
# Software Watchdog with Forced Bus Termination

This block is a software watchdog that runs on the bus clock. Firmware keeps it quiet by writing a two-byte key pair to a service register. If no valid pair arrives within the selected period, the block raises an interrupt. During the acknowledge cycle for that interrupt it presents a programmable 8-bit vector. The period is a power of two, chosen by a prescale bit and a two-bit delay code. A new choice is copied into the running timer only when a full key pair is accepted.

If escalation is enabled and the interrupt stays unacknowledged for one further period, the block drives a one-clock transfer-acknowledge pulse. This pulse ends a bus cycle that would otherwise hang and keep the acknowledge from running. Each forced pulse sets a sticky status flag, which software clears by writing one to it. Writes to the control and vector registers need a supervisor-qualify input.

Top module: `soft_watchdog`

## Requirements
- R1: After reset, irq and ta_force are low, the control register (address 0) reads 0x00, the status register (address 1) reads 0x00, and the vector register holds 0x0F.
- R2: A write of 0x55 to address 3 followed directly (next write to address 3) by 0xAA restarts the count; irq rises exactly 2^E clock edges after the edge that accepted 0xAA, where E is the active exponent.
- R3: At address 3, any byte other than 0xAA that follows an accepted 0x55 cancels the pair, and so does 0xAA written without a preceding 0x55; a repeated 0x55 starts a new pair, so the writes 0x55, 0x55, 0xAA form a valid service.
- R4: Control bits [2:1] form the delay code d. With control bit 3 clear, E = 9 + 2·d (2^9, 2^11, 2^13, 2^15 clocks).
- R5: With control bit 3 set, E = 22 + 2·d (2^22 up to 2^28 clocks).
- R6: A new prescale bit or delay code does not change the running period until the next accepted service pair.
- R7: irq stays high until iack is sampled high; iack then clears it at that edge.
- R8: vec_out carries the vector register while iack is high and is 0x00 otherwise; the vector register (address 2) reads as 0x00.
- R9: With control bit 0 set, when irq has been high for 2^E further edges, ta_force is high for exactly one clock and status bit 0 is set at that edge. With bit 0 clear, no pulse occurs.
- R10: Writing 1 to status bit 0 clears it; writing 0 leaves it set.
- R11: Writes to the control and vector registers with sup_ok low are ignored.
- R12: iack clears the escalation count, so a later interrupt waits a full 2^E edges before ta_force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address (0 control, 1 status, 2 vector, 3 service) |
| wdata | input | 8 | Write data |
| sup_ok | input | 1 | Supervisor qualifier for control and vector writes |
| rdata | output | 8 | Read data for addr (combinational) |
| iack | input | 1 | Interrupt-acknowledge cycle indicator |
| irq | output | 1 | Watchdog interrupt request |
| vec_out | output | 8 | Interrupt vector, valid while iack is high |
| ta_force | output | 1 | One-clock forced transfer-acknowledge |

## Verification
The checker assumes that iack is held for a single clock per acknowledge. It also assumes that an acknowledge never lands on the same edge as a timer expiry, because the expiry wins that race. The stimulus therefore acknowledges several cycles after an interrupt rises and services the block well before the next expiry. The 2^22 and longer periods can only be observed as the absence of an interrupt within a window, so the bench checks that no interrupt appears for 40,000 cycles after selecting one.

// File: rtl/swd_pkg.sv
package swd_pkg;

   typedef enum logic [1:0] {
      REG_CTRL = 2'd0,
      REG_STAT = 2'd1,
      REG_VEC  = 2'd2,
      REG_SVC  = 2'd3
   } swd_addr_e;

   typedef struct packed {
      logic       prescale;
      logic [1:0] delay;
      logic       ta_en;
   } swd_ctrl_t;

   typedef struct packed {
      logic       prescale;
      logic [1:0] delay;
   } swd_sel_t;

   localparam logic [7:0] SVC_KEY_A = 8'h55;
   localparam logic [7:0] SVC_KEY_B = 8'hAA;

   function automatic int unsigned period_exp(input logic prescale,
                                              input logic [1:0] delay,
                                              input int unsigned lo,
                                              input int unsigned hi,
                                              input int unsigned step);
      return (prescale ? hi : lo) + step * 32'(delay);
   endfunction

endpackage

// File: rtl/swd_timer.sv
module swd_timer #(
   parameter int unsigned W = 28
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic         clear,
   input  logic [W-1:0] term,
   output logic         hit
);
   logic [W-1:0] cnt_q;

   assign hit = run && (cnt_q == term);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (clear || hit) cnt_q <= '0;
      else if (run)          cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/swd_regs.sv
module swd_regs
   import swd_pkg::*;
#(
   parameter int unsigned  DATA_W    = 8,
   parameter logic [7:0]   VEC_RESET = 8'h0F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              sup_ok,
   input  logic              flag_set,
   output swd_ctrl_t         ctrl,
   output logic [DATA_W-1:0] vec,
   output logic              flag,
   output logic              svc_done,
   output logic [DATA_W-1:0] rdata
);
   logic armed_q;
   logic wr_svc;

   assign wr_svc   = wr_en && (addr == REG_SVC);
   assign svc_done = wr_svc && armed_q && (wdata == SVC_KEY_B);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl    <= '0;
         vec     <= VEC_RESET;
         flag    <= 1'b0;
         armed_q <= 1'b0;
      end else begin
         if (wr_en && sup_ok && addr == REG_CTRL) ctrl <= swd_ctrl_t'(wdata[3:0]);
         if (wr_en && sup_ok && addr == REG_VEC)  vec  <= wdata;
         if (flag_set)                                    flag <= 1'b1;
         else if (wr_en && addr == REG_STAT && wdata[0]) flag <= 1'b0;
         if (wr_svc) armed_q <= (wdata == SVC_KEY_A);
      end
   end

   always_comb begin
      case (addr)
         REG_CTRL: rdata = {{(DATA_W-4){1'b0}}, ctrl};
         REG_STAT: rdata = {{(DATA_W-1){1'b0}}, flag};
         default:  rdata = '0;
      endcase
   end
endmodule

// File: rtl/soft_watchdog.sv
module soft_watchdog
   import swd_pkg::*;
#(
   parameter int unsigned CNT_W      = 28,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned EXP_LO     = 9,
   parameter int unsigned EXP_HI     = 22,
   parameter int unsigned EXP_STEP   = 2,
   parameter logic [7:0]  VEC_RESET  = 8'h0F,
   parameter bit          ESC_ENABLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              sup_ok,
   output logic [DATA_W-1:0] rdata,
   input  logic              iack,
   output logic              irq,
   output logic [DATA_W-1:0] vec_out,
   output logic              ta_force
);
   localparam int unsigned EXP_MAX = EXP_HI + 3 * EXP_STEP;

   if (EXP_MAX > CNT_W) begin : g_bad_width
      $error("soft_watchdog: CNT_W too small for the longest period");
   end
   if (DATA_W != 8) begin : g_bad_data
      $error("soft_watchdog: service keys need DATA_W of 8");
   end
   if (EXP_LO + 3 * EXP_STEP > CNT_W) begin : g_bad_lo
      $error("soft_watchdog: short range exceeds counter");
   end

   swd_ctrl_t         ctrl;
   logic [DATA_W-1:0] vec_q;
   logic              flag;
   logic              svc_done;
   logic              main_hit;
   logic              esc_hit;
   swd_sel_t          act_sel_q;
   int unsigned       exp_sel;
   logic [CNT_W-1:0]  term;

   swd_regs #(.DATA_W(DATA_W), .VEC_RESET(VEC_RESET)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .addr     (addr),
      .wdata    (wdata),
      .sup_ok   (sup_ok),
      .flag_set (ta_force_d),
      .ctrl     (ctrl),
      .vec      (vec_q),
      .flag     (flag),
      .svc_done (svc_done),
      .rdata    (rdata)
   );

   logic ta_force_d;
   assign ta_force_d = esc_hit;

   always_comb begin
      exp_sel = period_exp(act_sel_q.prescale, act_sel_q.delay, EXP_LO, EXP_HI, EXP_STEP);
      term    = (CNT_W'(1) << exp_sel) - CNT_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        act_sel_q <= '0;
      else if (svc_done) act_sel_q <= '{prescale: ctrl.prescale, delay: ctrl.delay};
   end

   swd_timer #(.W(CNT_W)) u_main (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (1'b1),
      .clear (svc_done),
      .term  (term),
      .hit   (main_hit)
   );

   if (ESC_ENABLE) begin : g_esc
      swd_timer #(.W(CNT_W)) u_esc (
         .clk   (clk),
         .rst_n (rst_n),
         .run   (irq && ctrl.ta_en),
         .clear (iack),
         .term  (term),
         .hit   (esc_hit)
      );
   end else begin : g_no_esc
      assign esc_hit = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq      <= 1'b0;
         ta_force <= 1'b0;
      end else begin
         if (main_hit)  irq <= 1'b1;
         else if (iack) irq <= 1'b0;
         ta_force <= esc_hit;
      end
   end

   assign vec_out = iack ? vec_q : '0;
endmodule

// File: rtl/swd_checker.sv
module swd_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_en,
   input logic [1:0] addr,
   input logic       wbit0,
   input logic       sup_ok,
   input logic       iack,
   input logic       irq,
   input logic       ta_force,
   input logic       main_hit,
   input logic       flag,
   input logic [7:0] vec_q
);
   AST_TA_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      ta_force |=> !ta_force);                                            // R9
   AST_TA_AFTER_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      ta_force |-> $past(irq));                                           // R9
   AST_FLAG_ON_TA: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> ta_force);                                          // R9
   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      flag && !(wr_en && addr == 2'd1 && wbit0) |=> flag);                // R10
   AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      irq && !iack |=> irq);                                              // R7
   AST_IACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      iack && !main_hit |=> !irq);                                        // R7
   AST_IRQ_FROM_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(main_hit));                                    // R2
   AST_VEC_GUARDED: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && addr == 2'd2 && !sup_ok |=> $stable(vec_q));               // R11
endmodule

bind soft_watchdog swd_checker u_swd_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .addr     (addr),
   .wbit0    (wdata[0]),
   .sup_ok   (sup_ok),
   .iack     (iack),
   .irq      (irq),
   .ta_force (ta_force),
   .main_hit (main_hit),
   .flag     (flag),
   .vec_q    (vec_q)
);

// File: tb/soft_watchdog_bench.sv
module soft_watchdog_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] addr = 2'd0;
   logic [7:0] wdata = 8'h00;
   logic       sup_ok = 1'b1;
   logic       iack = 1'b0;
   logic [7:0] rdata;
   logic [7:0] vec_out;
   logic       irq;
   logic       ta_force;

   always #5 clk = ~clk;

   soft_watchdog u_soft_watchdog (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .sup_ok(sup_ok), .rdata(rdata), .iack(iack), .irq(irq),
      .vec_out(vec_out), .ta_force(ta_force)
   );

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int checks = 0;
   int fails  = 0;
   int last_edge = 0;
   bit done = 0;

   typedef struct {
      bit    is_ta;
      int    at;
      string req;
   } ev_t;
   ev_t expq[$];

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic expect_ev(input bit is_ta, input int at, input string req);
      ev_t e;
      e.is_ta = is_ta; e.at = at; e.req = req;
      expq.push_back(e);
   endtask

   task automatic observe(input bit is_ta);
      ev_t e;
      if (expq.size() == 0) begin
         check(1'b0, is_ta ? "R9" : "R2", "unexpected event at cycle", cyc, 0);
      end else begin
         e = expq.pop_front();
         check(e.is_ta == is_ta, e.req, "event kind (1=ta)", is_ta, e.is_ta);
         check(e.at == cyc, e.req, "event cycle", cyc, e.at);
      end
   endtask

   // monitor
   logic irq_prev = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (irq && !irq_prev) observe(1'b0);
         if (ta_force) observe(1'b1);
      end
      irq_prev = irq;
   end

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
      last_edge = cyc;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] v);
      @(negedge clk);
      addr = a;
      #1 v = rdata;
   endtask

   task automatic service(output int e);
      wr(2'd3, 8'h55);
      wr(2'd3, 8'hAA);
      e = last_edge;
   endtask

   task automatic ack(input logic [7:0] exp_vec, input string req);
      @(negedge clk);
      iack = 1'b1;
      #1 check(vec_out == exp_vec, req, "vec_out during iack", vec_out, exp_vec);
      @(negedge clk);
      iack = 1'b0;
      #1 check(irq == 1'b0, "R7", "irq after iack", irq, 0);
   endtask

   task automatic wait_until(input int c);
      while (cyc < c) @(negedge clk);
   endtask

   initial begin
      repeat (180000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run hung actual=%0d expected=%0d", cyc, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      int s;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      #1 check(irq == 1'b0 && ta_force == 1'b0, "R1", "irq/ta after reset", {irq, ta_force}, 0);
      rd(2'd0, v); check(v == 8'h00, "R1", "control reset", v, 8'h00);
      rd(2'd1, v); check(v == 8'h00, "R1", "status reset", v, 8'h00);
      rd(2'd2, v); check(v == 8'h00, "R8", "vector reads zero", v, 8'h00);
      check(vec_out == 8'h00, "R8", "vec_out idle", vec_out, 8'h00);
      ack(8'h0F, "R1");

      // R2, R7 basic timeout
      service(s);
      expect_ev(1'b0, s + 512, "R2");
      wait_until(s + 520);
      check(irq == 1'b1, "R7", "irq held", irq, 1);
      ack(8'h0F, "R8");

      // R3 broken and repeated sequences
      service(s);
      wr(2'd3, 8'h55); wr(2'd3, 8'h12); wr(2'd3, 8'hAA);
      expect_ev(1'b0, s + 512, "R3");
      wait_until(s + 520);
      ack(8'h0F, "R3");
      wr(2'd3, 8'h55);
      service(s);
      expect_ev(1'b0, s + 512, "R3");
      wait_until(s + 520);
      ack(8'h0F, "R3");

      // R6 deferred selection, R4 period table
      service(s);
      wr(2'd0, 8'h02);
      expect_ev(1'b0, s + 512, "R6");
      wait_until(s + 520);
      ack(8'h0F, "R6");
      service(s);
      expect_ev(1'b0, s + 2048, "R4");
      wait_until(s + 2052);
      ack(8'h0F, "R4");
      wr(2'd0, 8'h04);
      service(s);
      expect_ev(1'b0, s + 8192, "R4");
      wait_until(s + 8196);
      ack(8'h0F, "R4");
      wr(2'd0, 8'h06);
      service(s);
      expect_ev(1'b0, s + 32768, "R4");
      wait_until(s + 32772);
      ack(8'h0F, "R4");

      // R5 prescaled range
      wr(2'd0, 8'h08);
      service(s);
      wait_until(s + 40000);
      check(irq == 1'b0, "R5", "no irq within 40000 cycles", irq, 0);
      wr(2'd0, 8'h00);
      service(s);

      // R11 supervisor gate
      sup_ok = 1'b0;
      wr(2'd0, 8'h07);
      wr(2'd2, 8'h33);
      sup_ok = 1'b1;
      rd(2'd0, v); check(v == 8'h00, "R11", "control after unqualified write", v, 8'h00);
      ack(8'h0F, "R11");

      // R9 escalation
      wr(2'd0, 8'h01);
      wr(2'd2, 8'hA5);
      rd(2'd0, v); check(v == 8'h01, "R11", "control after qualified write", v, 8'h01);
      service(s);
      expect_ev(1'b0, s + 512, "R9");
      expect_ev(1'b1, s + 1024, "R9");
      wait_until(s + 1030);
      check(ta_force == 1'b0, "R9", "ta_force single pulse", ta_force, 0);
      rd(2'd1, v); check(v == 8'h01, "R9", "status flag set", v, 8'h01);
      ack(8'hA5, "R8");
      service(s);
      wr(2'd1, 8'h00);
      rd(2'd1, v); check(v == 8'h01, "R10", "flag after write 0", v, 8'h01);
      wr(2'd1, 8'h01);
      rd(2'd1, v); check(v == 8'h00, "R10", "flag after write 1", v, 8'h00);

      // R12 iack clears escalation count
      service(s);
      expect_ev(1'b0, s + 512, "R12");
      wait_until(s + 800);
      ack(8'hA5, "R12");
      expect_ev(1'b0, s + 1024, "R12");
      expect_ev(1'b1, s + 1536, "R12");
      wait_until(s + 1540);
      ack(8'hA5, "R12");

      // R9 escalation disabled
      wr(2'd0, 8'h00);
      wr(2'd1, 8'h01);
      service(s);
      expect_ev(1'b0, s + 512, "R9");
      wait_until(s + 1200);
      check(irq == 1'b1, "R9", "irq still pending", irq, 1);
      rd(2'd1, v); check(v == 8'h00, "R9", "no flag when disabled", v, 8'h00);
      ack(8'hA5, "R9");
      service(s);

      repeat (20) @(negedge clk);
      while (expq.size() > 0) begin
         ev_t e;
         e = expq.pop_front();
         check(1'b0, e.req, "missing event at cycle", 0, e.at);
      end
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule